// File: doc/BRIEF.md
# Scatter/Gather Descriptor Chain Walker

This block steps a DMA channel through a chain of transfer descriptors held in memory. Software writes the first descriptor straight into the channel registers and pulses a go input. The walker then starts a block transfer and waits for the data mover to report that the block is finished. After that it reads the next pointer register. A zero pointer ends the chain with a one-cycle completion pulse. Any other value makes the walker fetch a four-word descriptor at that address, load it into the channel registers and start the next block.

Descriptors are read through a read port with a request channel and a response channel, each using valid/ready. Only one read is outstanding at a time. The request channel obeys back-pressure: once the walker raises the request valid, it holds both valid and address steady until ready is seen at a clock edge. The walker raises response ready only after its request has been accepted. An error on a response abandons the chain and sets an error flag. That flag stays set until the next accepted go.

Top module: `chain_fetch_engine`

## Requirements
- R1: After reset the walker is idle: busy, rd_req_valid, rd_rsp_ready, xfer_start, chain_done and chain_err are all 0, and the four channel registers read 0.
- R2: A go pulse accepted while idle loads prog_src, prog_dst, prog_link and prog_ctrl into ch_src, ch_dst, ch_link and ch_ctrl at that edge. xfer_start is then high in the following cycle.
- R3: When xfer_done arrives and ch_link with its two low bits cleared is zero, the walker issues no read. chain_done is high for exactly one cycle after that edge, and busy is 0 in the same cycle.
- R4: When xfer_done arrives with a non-zero pointer, the walker issues exactly four reads at addresses B, B+4, B+8 and B+12, in that order. B is ch_link with its two low bits forced to zero.
- R5: Descriptor words 0, 1, 2 and 3 are written into ch_src, ch_dst, ch_link and ch_ctrl respectively, each on the edge at which its response is accepted.
- R6: Once the fourth word is accepted, xfer_start is high for exactly one cycle. The walker then waits for xfer_done. A chain of N fetched descriptors therefore yields N+1 start pulses.
- R7: While rd_req_valid is high and rd_req_ready is low, rd_req_valid stays high and rd_req_addr stays unchanged in the next cycle.
- R8: A new request is never raised while a read is outstanding. After a request is accepted, rd_req_valid is low and rd_rsp_ready is high until the response is taken.
- R9: A response accepted with rd_rsp_err high writes no register and triggers no further read or start. The walker goes idle without chain_done and sets chain_err. chain_err clears at the next accepted go.
- R10: A go pulse while busy is ignored: the channel registers and the walker's progress are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prog_go | input | 1 | Load first descriptor and start the chain |
| prog_src | input | WORD_W | First descriptor source address |
| prog_dst | input | WORD_W | First descriptor destination address |
| prog_link | input | WORD_W | First descriptor next pointer |
| prog_ctrl | input | WORD_W | First descriptor control word |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request ready |
| rd_req_addr | output | WORD_W | Read byte address |
| rd_rsp_valid | input | 1 | Read response valid |
| rd_rsp_ready | output | 1 | Read response ready |
| rd_rsp_data | input | WORD_W | Read response word |
| rd_rsp_err | input | 1 | Read response error |
| xfer_start | output | 1 | One-cycle pulse starting a block transfer |
| xfer_done | input | 1 | Block transfer finished (pulse) |
| ch_src | output | WORD_W | Channel source address register |
| ch_dst | output | WORD_W | Channel destination address register |
| ch_link | output | WORD_W | Channel next pointer register |
| ch_ctrl | output | WORD_W | Channel control register |
| busy | output | 1 | Walker not idle |
| chain_done | output | 1 | One-cycle end-of-chain pulse |
| chain_err | output | 1 | Chain aborted by a read error (sticky) |

## Verification
Every result lands a fixed number of edges after its cause. The registers are loaded on the edge that accepts the go or the response. xfer_start appears in the cycle after that edge. chain_done and the error flag appear in the cycle after the edge that samples xfer_done or the error response. A request that is accepted is followed by a response handshake no sooner than two edges later.

The bench drives inputs on falling edges and reads outputs on the next falling edge after the edge that should produce them, so each check lands on its due cycle. The memory model runs on rising edges and checks each accepted address, the hold rule under stall and the single-outstanding rule at the handshake edge itself.

// File: rtl/chain_pkg.sv
package chain_pkg;
  localparam int unsigned ITEM_WORDS = 4;
  localparam int unsigned IDX_W      = $clog2(ITEM_WORDS);
  localparam int unsigned ALIGN_BITS = 2;

  // word position inside a descriptor; the walker depends on this order
  localparam logic [IDX_W-1:0] WPOS_SRC  = 2'd0;
  localparam logic [IDX_W-1:0] WPOS_DST  = 2'd1;
  localparam logic [IDX_W-1:0] WPOS_LINK = 2'd2;
  localparam logic [IDX_W-1:0] WPOS_CTRL = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_KICK,
    ST_RUN,
    ST_REQ,
    ST_RSP
  } walk_state_t;
endpackage

// File: rtl/chain_addr_gen.sv
module chain_addr_gen
  import chain_pkg::*;
#(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] ptr,
  input  logic              step,
  output logic [WORD_W-1:0] addr,
  output logic [IDX_W-1:0]  idx,
  output logic              last
);
  localparam logic [WORD_W-1:0] LOW_MASK = WORD_W'((1 << ALIGN_BITS) - 1);

  logic [WORD_W-1:0] base_q;
  logic [IDX_W-1:0]  idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      idx_q  <= '0;
    end else if (load) begin
      base_q <= ptr & ~LOW_MASK;
      idx_q  <= '0;
    end else if (step) begin
      idx_q  <= idx_q + 1'b1;
    end
  end

  assign addr = base_q + (WORD_W'(idx_q) << ALIGN_BITS);
  assign idx  = idx_q;
  assign last = (idx_q == IDX_W'(ITEM_WORDS - 1));
endmodule

// File: rtl/chain_regfile.sv
module chain_regfile
  import chain_pkg::*;
#(
  parameter int unsigned WORD_W = 32
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               prog_load,
  input  logic [ITEM_WORDS-1:0][WORD_W-1:0]  prog_words,
  input  logic                               fetch_we,
  input  logic [IDX_W-1:0]                   fetch_idx,
  input  logic [WORD_W-1:0]                  fetch_data,
  output logic [ITEM_WORDS-1:0][WORD_W-1:0]  words
);
  for (genvar g = 0; g < ITEM_WORDS; g++) begin : g_word
    logic [WORD_W-1:0] r_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        r_q <= '0;
      else if (prog_load)
        r_q <= prog_words[g];
      else if (fetch_we && (fetch_idx == IDX_W'(g)))
        r_q <= fetch_data;
    end
    assign words[g] = r_q;
  end
endmodule

// File: rtl/chain_seq.sv
module chain_seq
  import chain_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic prog_go,
  input  logic xfer_done,
  input  logic link_zero,
  input  logic req_ready,
  input  logic rsp_valid,
  input  logic rsp_err,
  input  logic last,
  output logic prog_load,
  output logic base_load,
  output logic step,
  output logic fetch_we,
  output logic xfer_start,
  output logic req_valid,
  output logic rsp_ready,
  output logic busy,
  output logic chain_done,
  output logic chain_err
);
  walk_state_t st_q, st_d;
  logic        done_q, err_q;
  logic        rsp_take;
  logic        blk_end;

  assign blk_end   = (st_q == ST_RUN) && xfer_done;
  assign rsp_take  = (st_q == ST_RSP) && rsp_valid;
  assign prog_load = (st_q == ST_IDLE) && prog_go;
  assign base_load = blk_end && !link_zero;
  assign fetch_we  = rsp_take && !rsp_err;
  assign step      = fetch_we && !last;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (prog_go)   st_d = ST_KICK;
      ST_KICK:                st_d = ST_RUN;
      ST_RUN:  if (xfer_done) st_d = link_zero ? ST_IDLE : ST_REQ;
      ST_REQ:  if (req_ready) st_d = ST_RSP;
      ST_RSP: begin
        if (rsp_valid) begin
          if (rsp_err)   st_d = ST_IDLE;
          else if (last) st_d = ST_KICK;
          else           st_d = ST_REQ;
        end
      end
      default:                st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= blk_end && link_zero;
      if (rsp_take && rsp_err)
        err_q <= 1'b1;
      else if (prog_load)
        err_q <= 1'b0;
    end
  end

  assign xfer_start = (st_q == ST_KICK);
  assign req_valid  = (st_q == ST_REQ);
  assign rsp_ready  = (st_q == ST_RSP);
  assign busy       = (st_q != ST_IDLE);
  assign chain_done = done_q;
  assign chain_err  = err_q;
endmodule

// File: rtl/chain_fetch_engine.sv
module chain_fetch_engine
  import chain_pkg::*;
#(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_go,
  input  logic [WORD_W-1:0] prog_src,
  input  logic [WORD_W-1:0] prog_dst,
  input  logic [WORD_W-1:0] prog_link,
  input  logic [WORD_W-1:0] prog_ctrl,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [WORD_W-1:0] rd_req_addr,
  input  logic              rd_rsp_valid,
  output logic              rd_rsp_ready,
  input  logic [WORD_W-1:0] rd_rsp_data,
  input  logic              rd_rsp_err,
  output logic              xfer_start,
  input  logic              xfer_done,
  output logic [WORD_W-1:0] ch_src,
  output logic [WORD_W-1:0] ch_dst,
  output logic [WORD_W-1:0] ch_link,
  output logic [WORD_W-1:0] ch_ctrl,
  output logic              busy,
  output logic              chain_done,
  output logic              chain_err
);
  localparam logic [WORD_W-1:0] LOW_MASK = WORD_W'((1 << ALIGN_BITS) - 1);

  logic                              prog_load, base_load, step, fetch_we, last;
  logic                              link_zero;
  logic [IDX_W-1:0]                  idx;
  logic [ITEM_WORDS-1:0][WORD_W-1:0] prog_words, words;

  assign prog_words[WPOS_SRC]  = prog_src;
  assign prog_words[WPOS_DST]  = prog_dst;
  assign prog_words[WPOS_LINK] = prog_link;
  assign prog_words[WPOS_CTRL] = prog_ctrl;

  assign ch_src    = words[WPOS_SRC];
  assign ch_dst    = words[WPOS_DST];
  assign ch_link   = words[WPOS_LINK];
  assign ch_ctrl   = words[WPOS_CTRL];
  assign link_zero = ((ch_link & ~LOW_MASK) == '0);

  chain_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .prog_go    (prog_go),
    .xfer_done  (xfer_done),
    .link_zero  (link_zero),
    .req_ready  (rd_req_ready),
    .rsp_valid  (rd_rsp_valid),
    .rsp_err    (rd_rsp_err),
    .last       (last),
    .prog_load  (prog_load),
    .base_load  (base_load),
    .step       (step),
    .fetch_we   (fetch_we),
    .xfer_start (xfer_start),
    .req_valid  (rd_req_valid),
    .rsp_ready  (rd_rsp_ready),
    .busy       (busy),
    .chain_done (chain_done),
    .chain_err  (chain_err)
  );

  chain_addr_gen #(.WORD_W(WORD_W)) u_addr (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (base_load),
    .ptr   (ch_link),
    .step  (step),
    .addr  (rd_req_addr),
    .idx   (idx),
    .last  (last)
  );

  chain_regfile #(.WORD_W(WORD_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .prog_load  (prog_load),
    .prog_words (prog_words),
    .fetch_we   (fetch_we),
    .fetch_idx  (idx),
    .fetch_data (rd_rsp_data),
    .words      (words)
  );
endmodule

// File: rtl/chain_fetch_engine_chk.sv
module chain_fetch_engine_chk #(
  parameter int unsigned WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              prog_go,
  input logic              rd_req_valid,
  input logic              rd_req_ready,
  input logic [WORD_W-1:0] rd_req_addr,
  input logic              rd_rsp_valid,
  input logic              rd_rsp_ready,
  input logic              rd_rsp_err,
  input logic              xfer_start,
  input logic              busy,
  input logic              chain_done,
  input logic              chain_err
);
  a_r2_start_after_go: assert property (@(posedge clk) disable iff (!rst_n)
    prog_go && !busy |=> xfer_start);

  a_r3_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    chain_done |=> !chain_done);

  a_r3_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    chain_done |-> !busy);

  a_r4_aligned_addr: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid |-> (rd_req_addr[1:0] == 2'b00));

  a_r6_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |=> !xfer_start);

  a_r7_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr));

  a_r8_wait_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && rd_req_ready |=> rd_rsp_ready && !rd_req_valid);

  a_r9_err_abort: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rsp_valid && rd_rsp_ready && rd_rsp_err |=> !busy && chain_err && !chain_done);
endmodule

bind chain_fetch_engine chain_fetch_engine_chk #(.WORD_W(WORD_W)) u_chk (.*);

// File: tb/test_chain_fetch_engine.sv
module test_chain_fetch_engine;
  localparam int W = 32;
  localparam logic [31:0] ERR_ADDR = 32'h58;

  typedef struct packed {
    logic [31:0] link;
    logic        stall;
    logic [3:0]  blocks;
    logic        err;
    logic [31:0] fsrc;
    logic [31:0] fctrl;
  } vec_t;

  // link, stall, start pulses, error, final ch_src, final ch_ctrl
  localparam vec_t VECS [5] = '{
    '{32'h00, 1'b0, 4'd1, 1'b0, 32'hA000_0000, 32'hC0DE_0000},
    '{32'h10, 1'b0, 4'd4, 1'b0, 32'h0000_1030, 32'h0000_C030},
    '{32'h41, 1'b1, 4'd2, 1'b0, 32'h0000_1040, 32'h0000_C040},
    '{32'h50, 1'b1, 4'd1, 1'b1, 32'h0000_1050, 32'hC0DE_0003},
    '{32'h20, 1'b0, 4'd3, 1'b0, 32'h0000_1030, 32'h0000_C030}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic prog_go = 1'b0;
  logic [W-1:0] prog_src = '0, prog_dst = '0, prog_link = '0, prog_ctrl = '0;
  logic rd_req_valid, rd_req_ready, rd_rsp_valid, rd_rsp_ready, rd_rsp_err;
  logic [W-1:0] rd_req_addr, rd_rsp_data;
  logic xfer_start, xfer_done = 1'b0;
  logic [W-1:0] ch_src, ch_dst, ch_link, ch_ctrl;
  logic busy, chain_done, chain_err;

  always #4 clk = ~clk;

  chain_fetch_engine #(.WORD_W(W)) i_chain_fetch_engine (.*);

  int checks = 0;
  int errors = 0;
  bit ended = 1'b0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // memory holding descriptors: word index = byte address / 4
  logic [31:0] mem [32];
  initial begin
    for (int i = 0; i < 32; i++) mem[i] = 32'h0;
    for (int b = 16; b <= 80; b += 16) begin
      mem[b/4]     = 32'h1000 | b;
      mem[b/4 + 1] = 32'h2000 | b;
      mem[b/4 + 3] = 32'hC000 | b;
    end
    mem[16/4 + 2] = 32'h23;  // low bits set, must be ignored
    mem[32/4 + 2] = 32'h30;
  end

  // memory model with request stall and single-cycle response latency
  logic        stall_en = 1'b0;
  logic        pending, held;
  logic [31:0] p_addr, held_addr;
  int          acc_cnt = 0;
  int          acc_mark = 0;
  int          done_cnt = 0;
  logic [31:0] exp_base = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      rd_req_ready <= 1'b1;
      rd_rsp_valid <= 1'b0;
      rd_rsp_data  <= '0;
      rd_rsp_err   <= 1'b0;
      pending      <= 1'b0;
      held         <= 1'b0;
      p_addr       <= '0;
      held_addr    <= '0;
    end else begin
      rd_req_ready <= stall_en ? ~rd_req_ready : 1'b1;
      if (held) begin
        check("R7 valid held", {31'b0, rd_req_valid}, 32'd1);
        check("R7 addr held", rd_req_addr, held_addr);
      end
      held      <= rd_req_valid && !rd_req_ready;
      held_addr <= rd_req_addr;
      if (chain_done) done_cnt <= done_cnt + 1;
      if (rd_req_valid && rd_req_ready) begin
        check("R8 one outstanding", {31'b0, pending | rd_rsp_valid}, 32'd0);
        check("R4 read address", rd_req_addr, exp_base + 32'(4 * (acc_cnt - acc_mark)));
        acc_cnt <= acc_cnt + 1;
        pending <= 1'b1;
        p_addr  <= rd_req_addr;
      end
      if (rd_rsp_valid && rd_rsp_ready) begin
        rd_rsp_valid <= 1'b0;
      end else if (pending) begin
        rd_rsp_valid <= 1'b1;
        rd_rsp_data  <= mem[p_addr[6:2]];
        rd_rsp_err   <= (p_addr == ERR_ADDR);
        pending      <= 1'b0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    vec_t v;
    logic [31:0] cur, exp_s, exp_d, exp_l, exp_c, b4;
    int blocks, dmark;
    bit fin, end_exp;

    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 busy", {31'b0, busy}, 32'd0);
    check("R1 req valid", {31'b0, rd_req_valid}, 32'd0);
    check("R1 rsp ready", {31'b0, rd_rsp_ready}, 32'd0);
    check("R1 start", {31'b0, xfer_start}, 32'd0);
    check("R1 flags", {30'b0, chain_done, chain_err}, 32'd0);
    check("R1 regs", ch_src | ch_dst | ch_link | ch_ctrl, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int r = 0; r < 5; r++) begin
      v = VECS[r];
      stall_en  = v.stall;
      prog_src  = 32'hA000_0000 | r;
      prog_dst  = 32'hB000_0000 | r;
      prog_link = v.link;
      prog_ctrl = 32'hC0DE_0000 | r;
      prog_go   = 1'b1;
      @(negedge clk);
      prog_go = 1'b0;
      check("R9 err cleared by go", {31'b0, chain_err}, 32'd0);
      exp_s = prog_src; exp_d = prog_dst; exp_l = prog_link; exp_c = prog_ctrl;
      cur = v.link;
      blocks = 0;
      fin = 1'b0;
      dmark = done_cnt;
      for (int t = 0; t < 2000 && !fin; t++) begin
        if (xfer_start) begin
          blocks++;
          check("R5 src", ch_src, exp_s);
          check("R5 dst", ch_dst, exp_d);
          check("R5 link", ch_link, exp_l);
          check("R5 ctrl", ch_ctrl, exp_c);
          @(negedge clk);
          check("R6 start one cycle", {31'b0, xfer_start}, 32'd0);
          @(negedge clk);
          acc_mark = acc_cnt;
          exp_base = cur & ~32'h3;
          xfer_done = 1'b1;
          @(negedge clk);
          xfer_done = 1'b0;
          end_exp = ((cur & ~32'h3) == 32'h0);
          check("R3 chain_done", {31'b0, chain_done}, {31'b0, end_exp});
          check("R3 busy", {31'b0, busy}, {31'b0, !end_exp});
          if (end_exp) begin
            fin = 1'b1;
            @(negedge clk);
            check("R3 done pulse width", {31'b0, chain_done}, 32'd0);
          end else begin
            b4 = (cur & ~32'h3) >> 2;
            exp_s = mem[b4]; exp_d = mem[b4 + 1];
            exp_l = mem[b4 + 2]; exp_c = mem[b4 + 3];
            cur = exp_l;
          end
        end else if (chain_err && !busy) begin
          fin = 1'b1;
        end else begin
          @(negedge clk);
        end
      end
      check("R6 start pulses", 32'(blocks), 32'(v.blocks));
      check("R9 err flag", {31'b0, chain_err}, {31'b0, v.err});
      check("R5 final src", ch_src, v.fsrc);
      check("R5 final ctrl", ch_ctrl, v.fctrl);
      if (v.err) begin
        repeat (3) @(negedge clk);
        check("R9 no done on abort", 32'(done_cnt - dmark), 32'd0);
        check("R9 stays idle", {30'b0, busy, rd_req_valid}, 32'd0);
        check("R9 link untouched", ch_link, v.link);
      end
      @(negedge clk);
    end

    // R10: go while busy is ignored
    stall_en  = 1'b0;
    prog_src  = 32'h0000_5A5A; prog_dst = 32'h0; prog_link = 32'h0; prog_ctrl = 32'h7;
    prog_go   = 1'b1;
    @(negedge clk);
    prog_go = 1'b0;
    check("R2 start after go", {31'b0, xfer_start}, 32'd1);
    check("R2 src loaded", ch_src, 32'h0000_5A5A);
    @(negedge clk);
    prog_src = 32'hDEAD_BEEF; prog_link = 32'h40; prog_go = 1'b1;
    @(negedge clk);
    prog_go = 1'b0;
    check("R10 src kept", ch_src, 32'h0000_5A5A);
    check("R10 link kept", ch_link, 32'h0);
    check("R10 no restart", {30'b0, xfer_start, busy}, 32'd1);
    xfer_done = 1'b1;
    @(negedge clk);
    xfer_done = 1'b0;
    check("R10 chain ends normally", {31'b0, chain_done}, 32'd1);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule